// File: doc/BRIEF.md
# CAN Message Mailbox Manager

This block keeps the message store of a CAN controller. There are sixteen mailboxes. The host configures each one as a receive slot, a transmit slot or unused, and gives it an identifier (11-bit standard or 29-bit extended), a length code and up to eight data bytes. The bit-level protocol engine sits outside the block. It hands in each received frame as one parallel record and takes each outgoing frame as one parallel record. Both directions use a valid/ready handshake.

On receive, the block masks the incoming identifier and compares it with every empty receive mailbox. The frame goes into the lowest-numbered mailbox that matches. Mailboxes 0 to 13 share one global mask. Mailboxes 14 and 15 each have a private mask. If no mailbox matches, the frame is dropped and a sticky loss flag is raised.

On transmit, the block presents one pending mailbox to the engine. A select input chooses the order: either the lowest mailbox number goes first, or the lowest arbitration value goes first. A 16-bit free-running counter stamps every frame that is stored or sent. Each mailbox has an event flag that is cleared by writing 1, and an enable that routes the flag to the interrupt output.

Top module: `can_mailbox_mgr`

## Requirements
- R1: After reset, the following hold:
  - Every mailbox reads state 0 (unused).
  - `flags`, `irq` and `rx_lost` are 0, `tx_valid` is 0 and `ts_now` is 0.
  - All three masks are all ones, so every identifier bit must match exactly.
- R2: `ts_now` increases by one on every clock and wraps at 16 bits.
- R3: Mailboxes 0 to 13 use the global mask. For a mask bit of 1, the corresponding identifier bit must match; for a mask bit of 0, that bit is ignored. The IDE flag must always be equal. A standard identifier occupies `id[28:18]`, and for standard frames only those bits take part in the comparison.
- R4: Mailbox 14 uses its own mask (`mask_sel`=1) and mailbox 15 uses its own mask (`mask_sel`=2). The global mask (`mask_sel`=0) does not affect these two mailboxes.
- R5: An accepted frame is written into the lowest-index empty receive mailbox (state 1) that matches. That mailbox then holds the frame's identifier, IDE flag, length code and data. Its time stamp equals `ts_now` in the cycle of the handshake, and its state becomes 2 (full).
- R6: A frame that matches no mailbox is dropped. `rx_lost` is then set one cycle later and stays set until `lost_clr` is pulsed.
- R7: With `tx_by_id`=0, pending mailboxes (state 3) are offered on the transmit port in order of increasing mailbox number.
- R8: With `tx_by_id`=1, pending mailboxes are offered in order of increasing arbitration value {base id, IDE, extension}. As a result, a standard frame goes before an extended frame with the same base identifier, and equal values go in mailbox order.
- R9: When `tx_valid` and `tx_ready` are both high at a clock edge, the offered mailbox becomes state 4 (sent) and captures `ts_now` of that cycle.
- R10: Completing a transmit or filling a receive mailbox sets that mailbox's bit in `flags`. Writing 1 to a bit of `flag_clr` clears that bit. `irq` is high whenever any flag is set together with its `irq_en` bit.
- R11: A full receive mailbox takes no further frames. Writing `cfg_mode`=1 to it again makes it empty and able to accept frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Mailbox configuration write strobe |
| cfg_mb | input | 4 | Mailbox being configured |
| cfg_mode | input | 2 | 0 unused, 1 receive, 2 transmit |
| cfg_ide | input | 1 | Extended identifier flag |
| cfg_id | input | 29 | Identifier |
| cfg_dlc | input | 4 | Length code |
| cfg_data | input | 64 | Payload |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 2 | 0 global, 1 mailbox 14, 2 mailbox 15 |
| mask_val | input | 29 | Mask value |
| tx_by_id | input | 1 | Transmit order: 1 by identifier, 0 by index |
| rx_valid | input | 1 | Received frame valid |
| rx_ready | output | 1 | Always 1 |
| rx_ide | input | 1 | Received IDE flag |
| rx_id | input | 29 | Received identifier |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received payload |
| tx_valid | output | 1 | A frame is offered |
| tx_ready | input | 1 | Engine takes the frame |
| tx_mb | output | 4 | Mailbox offered |
| tx_ide | output | 1 | Offered IDE flag |
| tx_id | output | 29 | Offered identifier |
| tx_dlc | output | 4 | Offered length code |
| tx_data | output | 64 | Offered payload |
| rd_mb | input | 4 | Mailbox to observe |
| rd_state | output | 3 | State of observed mailbox |
| rd_ide | output | 1 | IDE flag of observed mailbox |
| rd_id | output | 29 | Identifier of observed mailbox |
| rd_dlc | output | 4 | Length code of observed mailbox |
| rd_data | output | 64 | Payload of observed mailbox |
| rd_ts | output | 16 | Time stamp of observed mailbox |
| irq_en | input | 16 | Per-mailbox interrupt enables |
| flag_clr | input | 16 | Write-1-to-clear for flags |
| flags | output | 16 | Per-mailbox event flags |
| irq | output | 1 | Interrupt request |
| lost_clr | input | 1 | Clears `rx_lost` |
| rx_lost | output | 1 | A frame was dropped |
| ts_now | output | 16 | Free-running time base |

## Verification
Two situations are hard to reach from the ports:
- A frame that skips a full mailbox and lands in a higher one that also matches.
- A standard and an extended frame with the same base identifier competing for the transmit port.

The stimulus fills mailbox 2 first, so that a second frame in the same masked range has to land in mailbox 5. A standard frame with nonzero low identifier bits is then sent to check that those bits are ignored. For transmit, seven mailboxes are loaded while `tx_ready` is low, and then all of them are drained back to back. The scoreboard predicts the order from mailbox numbers in one pass and from arbitration values in the other, including a pair of mailboxes with equal identifiers.

// File: rtl/can_mailbox_mgr.sv
module can_mailbox_mgr #(
  parameter int NMB = 16,
  parameter int IDW = 29,
  parameter int SIDW = 11,
  parameter int DW = 64,
  parameter int TSW = 16,
  localparam int MBW = $clog2(NMB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [MBW-1:0] cfg_mb,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_ide,
  input  logic [IDW-1:0] cfg_id,
  input  logic [3:0]     cfg_dlc,
  input  logic [DW-1:0]  cfg_data,
  input  logic           mask_we,
  input  logic [1:0]     mask_sel,
  input  logic [IDW-1:0] mask_val,
  input  logic           tx_by_id,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic           rx_ide,
  input  logic [IDW-1:0] rx_id,
  input  logic [3:0]     rx_dlc,
  input  logic [DW-1:0]  rx_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [MBW-1:0] tx_mb,
  output logic           tx_ide,
  output logic [IDW-1:0] tx_id,
  output logic [3:0]     tx_dlc,
  output logic [DW-1:0]  tx_data,
  input  logic [MBW-1:0] rd_mb,
  output logic [2:0]     rd_state,
  output logic           rd_ide,
  output logic [IDW-1:0] rd_id,
  output logic [3:0]     rd_dlc,
  output logic [DW-1:0]  rd_data,
  output logic [TSW-1:0] rd_ts,
  input  logic [NMB-1:0] irq_en,
  input  logic [NMB-1:0] flag_clr,
  output logic [NMB-1:0] flags,
  output logic           irq,
  input  logic           lost_clr,
  output logic           rx_lost,
  output logic [TSW-1:0] ts_now
);
  localparam int EXTW = IDW - SIDW;
  localparam int KW = IDW + 1;
  localparam int MB_A = NMB - 2;
  localparam int MB_B = NMB - 1;
  localparam logic [2:0] ST_OFF = 3'd0, ST_RXE = 3'd1, ST_RXF = 3'd2,
                         ST_TXP = 3'd3, ST_TXD = 3'd4;
  localparam logic [IDW-1:0] STD_BITS = {{SIDW{1'b1}}, {EXTW{1'b0}}};

  logic [2:0]     st_q   [NMB];
  logic           ide_q  [NMB];
  logic [IDW-1:0] id_q   [NMB];
  logic [3:0]     dlc_q  [NMB];
  logic [DW-1:0]  data_q [NMB];
  logic [TSW-1:0] stamp_q[NMB];
  logic [IDW-1:0] gmask, mask_a, mask_b;
  logic [TSW-1:0] ts_q;
  logic [NMB-1:0] flag_q;
  logic           lost_q;

  logic [NMB-1:0] rx_match, rx_store, tx_onehot;
  logic           rx_drop, tx_fire, tx_found;
  logic [MBW-1:0] tx_sel;
  logic [KW-1:0]  best_key;

  always_comb begin
    for (int i = 0; i < NMB; i++) begin
      logic [IDW-1:0] mk;
      mk = (i == MB_A) ? mask_a : (i == MB_B) ? mask_b : gmask;
      if (!rx_ide) mk = mk & STD_BITS;
      rx_match[i] = (st_q[i] == ST_RXE) && (ide_q[i] == rx_ide) &&
                    (((rx_id ^ id_q[i]) & mk) == '0) &&
                    !(cfg_we && cfg_mb == MBW'(i));
    end
  end

  assign rx_store = rx_valid ? (rx_match & (~rx_match + NMB'(1))) : '0;
  assign rx_drop  = rx_valid && (rx_match == '0);
  assign rx_ready = 1'b1;

  always_comb begin
    tx_found = 1'b0;
    tx_sel   = '0;
    best_key = '1;
    for (int i = 0; i < NMB; i++) begin
      logic [KW-1:0] k;
      k = {id_q[i][IDW-1 -: SIDW], ide_q[i], ide_q[i] ? id_q[i][EXTW-1:0] : EXTW'(0)};
      if (st_q[i] == ST_TXP && (!tx_found || (tx_by_id && k < best_key))) begin
        tx_found = 1'b1;
        tx_sel   = MBW'(i);
        best_key = k;
      end
    end
  end

  assign tx_valid  = tx_found;
  assign tx_fire   = tx_valid && tx_ready;
  assign tx_onehot = tx_fire ? (NMB'(1) << tx_sel) : '0;
  assign tx_mb     = tx_sel;
  assign tx_ide    = ide_q[tx_sel];
  assign tx_id     = id_q[tx_sel];
  assign tx_dlc    = dlc_q[tx_sel];
  assign tx_data   = data_q[tx_sel];

  assign rd_state = st_q[rd_mb];
  assign rd_ide   = ide_q[rd_mb];
  assign rd_id    = id_q[rd_mb];
  assign rd_dlc   = dlc_q[rd_mb];
  assign rd_data  = data_q[rd_mb];
  assign rd_ts    = stamp_q[rd_mb];

  assign flags   = flag_q;
  assign irq     = |(flag_q & irq_en);
  assign rx_lost = lost_q;
  assign ts_now  = ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      gmask  <= '1;
      mask_a <= '1;
      mask_b <= '1;
      flag_q <= '0;
      lost_q <= 1'b0;
      for (int i = 0; i < NMB; i++) begin
        st_q[i]    <= ST_OFF;
        ide_q[i]   <= 1'b0;
        id_q[i]    <= '0;
        dlc_q[i]   <= '0;
        data_q[i]  <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      ts_q <= ts_q + TSW'(1);
      if (mask_we) begin
        case (mask_sel)
          2'd0:    gmask  <= mask_val;
          2'd1:    mask_a <= mask_val;
          2'd2:    mask_b <= mask_val;
          default: ;
        endcase
      end
      if (rx_drop) lost_q <= 1'b1;
      else if (lost_clr) lost_q <= 1'b0;
      flag_q <= (flag_q & ~flag_clr) | rx_store | tx_onehot;
      for (int i = 0; i < NMB; i++) begin
        if (cfg_we && cfg_mb == MBW'(i)) begin
          ide_q[i]  <= cfg_ide;
          id_q[i]   <= cfg_id;
          dlc_q[i]  <= cfg_dlc;
          data_q[i] <= cfg_data;
          case (cfg_mode)
            2'd1:    st_q[i] <= ST_RXE;
            2'd2:    st_q[i] <= ST_TXP;
            default: st_q[i] <= ST_OFF;
          endcase
        end else if (rx_store[i]) begin
          ide_q[i]   <= rx_ide;
          id_q[i]    <= rx_id;
          dlc_q[i]   <= rx_dlc;
          data_q[i]  <= rx_data;
          stamp_q[i] <= ts_q;
          st_q[i]    <= ST_RXF;
        end else if (tx_onehot[i]) begin
          stamp_q[i] <= ts_q;
          st_q[i]    <= ST_TXD;
        end
      end
    end
  end

  p_ts_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts_q == $past(ts_q) + TSW'(1));

  p_single_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_store));

  p_drop_sets_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> lost_q);

  p_lost_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !lost_clr) |=> lost_q);

  p_sent_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (flag_q & $past(tx_onehot)) != '0);
endmodule

// File: tb/can_mailbox_mgr_test.sv
module can_mailbox_mgr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, mask_we = 0, tx_by_id = 0, rx_valid = 0, tx_ready = 0, lost_clr = 0;
  logic [3:0]  cfg_mb = 0, cfg_dlc = 0, rx_dlc = 0, rd_mb = 0;
  logic [1:0]  cfg_mode = 0, mask_sel = 0;
  logic        cfg_ide = 0, rx_ide = 0;
  logic [28:0] cfg_id = 0, mask_val = 0, rx_id = 0;
  logic [63:0] cfg_data = 0, rx_data = 0;
  logic [15:0] irq_en = 0, flag_clr = 0;
  logic        rx_ready, tx_valid, tx_ide, rd_ide, irq, rx_lost;
  logic [3:0]  tx_mb, tx_dlc, rd_dlc;
  logic [28:0] tx_id, rd_id;
  logic [63:0] tx_data, rd_data;
  logic [2:0]  rd_state;
  logic [15:0] rd_ts, flags, ts_now;

  int checks = 0, failures = 0;
  logic [32:0] expq[$];
  logic [15:0] exp_ts[16];

  can_mailbox_mgr uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [28:0] sid(input logic [10:0] b);
    return {b, 18'b0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int mb, input int mode, input logic ide, input logic [28:0] id,
                     input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_mb = 4'(mb); cfg_mode = 2'(mode); cfg_ide = ide; cfg_id = id;
    cfg_dlc = dlc; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_mask(input int sel, input logic [28:0] v);
    @(negedge clk);
    mask_we = 1; mask_sel = 2'(sel); mask_val = v;
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic send(input logic ide, input logic [28:0] id, input logic [3:0] dlc,
                      input logic [63:0] d, output logic [15:0] t);
    @(negedge clk);
    rx_valid = 1; rx_ide = ide; rx_id = id; rx_dlc = dlc; rx_data = d;
    #1 t = ts_now;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic look(input int mb);
    rd_mb = 4'(mb);
    #1;
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    tx_ready = 1;
    for (int k = 0; k < 60 && expq.size() != 0; k++) @(negedge clk);
    tx_ready = 0;
    chk({tag, " queue drained"}, 64'(expq.size()), 0);
    #1 chk({tag, " nothing left pending"}, 64'(tx_valid), 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && tx_valid && tx_ready) begin
        if (expq.size() == 0) chk("R7/R8 unexpected transmit", 64'(tx_mb), 64'hFF);
        else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk("R7/R8 transmit mailbox", 64'(tx_mb), 64'(e[32:29]));
          chk("R7/R8 transmit identifier", 64'(tx_id), 64'(e[28:0]));
          exp_ts[tx_mb] = ts_now;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] t0, t2, t5, t14, t15, tx;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 tx_valid", 64'(tx_valid), 0);
    chk("R1 flags", 64'(flags), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 lost", 64'(rx_lost), 0);
    chk("R1 ts", 64'(ts_now), 0);
    look(0); chk("R1 state", 64'(rd_state), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1 t0 = ts_now;
    repeat (5) @(negedge clk);
    #1 chk("R2 timer step", 64'(ts_now), 64'(16'(t0 + 5)));

    set_mask(0, 29'h1FFF_FFFF & ~(29'hF << 18));
    set_mask(2, 29'h0);
    cfg(2, 1, 0, sid(11'h120), 0, 0);
    cfg(5, 1, 0, sid(11'h120), 0, 0);
    cfg(14, 1, 0, sid(11'h300), 0, 0);
    cfg(15, 1, 1, 29'h0ABCDEF, 0, 0);

    send(0, sid(11'h123), 4'd8, 64'h1122334455667788, t2);
    look(2);
    chk("R3 masked match state", 64'(rd_state), 2);
    chk("R5 stored id", 64'(rd_id), 64'(sid(11'h123)));
    chk("R5 stored data", 64'(rd_data), 64'h1122334455667788);
    chk("R5 stored dlc", 64'(rd_dlc), 8);
    chk("R5 stamp", 64'(rd_ts), 64'(t2));

    send(0, sid(11'h125), 4'd2, 64'hBEEF, t5);
    look(5);
    chk("R11 full skipped, R5 next mailbox", 64'(rd_state), 2);
    chk("R5 stamp mb5", 64'(rd_ts), 64'(t5));
    look(2); chk("R11 full mailbox unchanged", 64'(rd_id), 64'(sid(11'h123)));

    send(0, sid(11'h301), 4'd1, 64'h1, tx);
    chk("R6 lost set", 64'(rx_lost), 1);
    look(14); chk("R4 private mask rejects", 64'(rd_state), 1);
    look(15); chk("R3 IDE must match", 64'(rd_state), 1);
    repeat (3) @(negedge clk);
    chk("R6 lost sticky", 64'(rx_lost), 1);
    lost_clr = 1; @(negedge clk); lost_clr = 0;
    chk("R6 lost cleared", 64'(rx_lost), 0);

    send(0, sid(11'h300) | 29'h3, 4'd3, 64'h33, t14);
    look(14);
    chk("R4 mb14 exact, R3 std low bits ignored", 64'(rd_state), 2);
    chk("R4 mb14 stamp", 64'(rd_ts), 64'(t14));
    send(1, 29'h1234567, 4'd4, 64'h44, t15);
    look(15);
    chk("R4 mb15 open mask", 64'(rd_state), 2);
    chk("R4 mb15 id", 64'(rd_id), 64'h1234567);
    chk("R6 no loss on accepted frames", 64'(rx_lost), 0);

    chk("R10 rx flags", 64'(flags), 64'h0000C024);
    chk("R10 irq disabled", 64'(irq), 0);
    irq_en = 16'h0020; #1;
    chk("R10 irq enabled", 64'(irq), 1);
    @(negedge clk); flag_clr = 16'h0020; @(negedge clk); flag_clr = 0; #1;
    chk("R10 w1c", 64'(flags), 64'h0000C004);
    chk("R10 irq after clear", 64'(irq), 0);
    @(negedge clk); flag_clr = 16'hFFFF; @(negedge clk); flag_clr = 0; irq_en = 0;

    cfg(2, 1, 0, sid(11'h120), 0, 0);
    look(2); chk("R11 rearm", 64'(rd_state), 1);
    send(0, sid(11'h121), 4'd1, 64'h9, tx);
    look(2); chk("R11 refilled", 64'(rd_state), 2);
    look(5); chk("R11 mb5 untouched", 64'(rd_id), 64'(sid(11'h125)));
    @(negedge clk); flag_clr = 16'hFFFF; @(negedge clk); flag_clr = 0;

    tx_by_id = 0;
    cfg(3, 2, 0, sid(11'h200), 1, 64'h3);
    cfg(7, 2, 0, sid(11'h100), 1, 64'h7);
    cfg(9, 2, 1, sid(11'h100) | 29'h5, 1, 64'h9);
    cfg(12, 2, 0, sid(11'h050), 1, 64'hC);
    #1;
    chk("R7 offered first", 64'(tx_mb), 3);
    chk("R9 held without ready", 64'(tx_valid), 1);
    expq.push_back({4'd3, sid(11'h200)});
    expq.push_back({4'd7, sid(11'h100)});
    expq.push_back({4'd9, sid(11'h100) | 29'h5});
    expq.push_back({4'd12, sid(11'h050)});
    drain("R7");
    look(3);
    chk("R9 sent state", 64'(rd_state), 4);
    chk("R9 sent stamp", 64'(rd_ts), 64'(exp_ts[3]));
    chk("R10 tx flags", 64'(flags), 64'h00001288);
    @(negedge clk); flag_clr = 16'hFFFF; @(negedge clk); flag_clr = 0;

    tx_by_id = 1;
    cfg(3, 2, 0, sid(11'h200), 1, 64'h3);
    cfg(7, 2, 0, sid(11'h100), 1, 64'h7);
    cfg(9, 2, 1, sid(11'h100) | 29'h5, 1, 64'h9);
    cfg(12, 2, 0, sid(11'h050), 1, 64'hC);
    cfg(1, 2, 1, sid(11'h050) | 29'h1, 1, 64'h1);
    cfg(10, 2, 0, sid(11'h400), 1, 64'hA);
    cfg(11, 2, 0, sid(11'h400), 1, 64'hB);
    expq.push_back({4'd12, sid(11'h050)});
    expq.push_back({4'd1, sid(11'h050) | 29'h1});
    expq.push_back({4'd7, sid(11'h100)});
    expq.push_back({4'd9, sid(11'h100) | 29'h5});
    expq.push_back({4'd3, sid(11'h200)});
    expq.push_back({4'd10, sid(11'h400)});
    expq.push_back({4'd11, sid(11'h400)});
    drain("R8");
    look(1); chk("R9 ext sent stamp", 64'(rd_ts), 64'(exp_ts[1]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule